// File: doc/BRIEF.md
# Page-Scope Codeword Read Sequencer

This block sits inside a NAND flash controller and turns a single execute strobe into a complete read sequence. It can read one codeword (single mode), every codeword of one page (page mode), or every codeword of several consecutive pages (run mode). Software does not act between codewords. For each codeword the block issues a read request to the data path and waits for its acknowledge, which carries that codeword's ECC flags. It then publishes a set of status records on a dedicated valid/ready stream, kept apart from the data path.

While a page or run read is in progress, the plain status register output reads as zero. Software must take codeword status from the stream. Single mode leaves that register visible. The completion interrupt fires only after the last codeword of the last page has finished and all its records have been accepted.

Back-pressure works as follows. A record stays on `st_data` with `st_valid` high until the consumer raises `st_ready`. No further read request is issued while a record is waiting, so a slow consumer stalls the whole walk and no record is ever lost.

Top module: `cw_page_seq`

## Requirements
- R1: After reset the following outputs are all 0: `busy`, `rd_req`, `st_valid`, `done_irq`, `err_sticky` and `stat_reg`.
- R2: A command is legal only if `cmd_word[21:0]` equals 0x000032. Bit 23 selects page mode and takes priority over bit 22, which selects run mode. With neither bit set the command is a single read. A non-zero top byte `cmd_word[31:24]` sets `rd_serial` to 1 for the whole sequence; a zero top byte sets it to 0.
- R3: Page mode reads codewords 0 to N-1 of page 0, in ascending order. N is `cw_per_page` latched at execute; a value of 0 counts as 1.
- R4: Run mode reads pages 0 to P-1. Within each page it reads every codeword in ascending order. P is `mp_pages` latched at execute; a value of 0 counts as 1.
- R5: Single mode reads one codeword per execute. An index starts at 0 after reset and goes up by one with each single execute. It wraps to 0 after `cw_per_page`-1. If the index has reached or passed `cw_per_page`, 0 is read instead.
- R6: `rd_req` stays high, with `rd_page` and `rd_cw` stable, until the cycle in which `rd_ack` is sampled high. Only one request is ever outstanding.
- R7: After each acknowledge the block emits one record for each set bit of `stat_mask` (latched at execute), lowest bit first. Each record is packed as {kind[26:25] = bit index, serial[24], page[23:16], codeword[15:8], flags[7:0]}. A zero mask emits no records.
- R8: `st_valid` stays high with `st_data` stable until `st_ready` is high. `rd_req` stays low while any record is pending.
- R9: `busy` rises on the clock edge after an accepted execute. `done_irq` is a one-cycle pulse on the edge of the final handshake, which is either the last acknowledge or the last record acceptance. `busy` falls on that same edge.
- R10: An execute that arrives while busy, or that carries an illegal command, is ignored. It sets `err_sticky`, which stays set until reset.
- R11: At each acknowledge, `stat_reg` takes the value of `rd_flags`. It reads 0 while a page or run read is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_word | input | 32 | Command word, decoded at execute |
| mp_pages | input | PAGE_W | Page count for run mode |
| cw_per_page | input | CW_W | Codewords per page |
| stat_mask | input | NREC | Selects which status records are published per codeword |
| exec_go | input | 1 | Execute strobe |
| rd_req | output | 1 | Codeword read request to the data path |
| rd_page | output | PAGE_W | Page index of the request |
| rd_cw | output | CW_W | Codeword index of the request |
| rd_serial | output | 1 | 1 for a serial flash, 0 for a parallel flash |
| rd_ack | input | 1 | Data path acknowledge |
| rd_flags | input | FLAG_W | ECC flags returned with the acknowledge |
| st_valid | output | 1 | Status record valid |
| st_ready | input | 1 | Status record accepted |
| st_data | output | log2(NREC)+1+PAGE_W+CW_W+FLAG_W | Status record |
| busy | output | 1 | Sequence in progress |
| done_irq | output | 1 | Completion pulse |
| err_sticky | output | 1 | Sticky error for a rejected execute |
| stat_reg | output | FLAG_W | Plain status register view |

## Verification
`busy` and the first `rd_req` appear one edge after `exec_go` is sampled. The first record, with `stat_reg` updated, appears one edge after `rd_ack` is sampled. Each following record or request appears one edge after the previous `st_ready` is sampled. `done_irq` is high exactly in the cycle after the final handshake and low in the cycle after that. The bench drives inputs on falling edges and samples on the next falling edge, so every check falls in the cycle where the result is due. While stalling `rd_ack` or `st_ready`, it checks every cycle that the pending output holds.

// File: rtl/cwseq_pkg.sv
package cwseq_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_PAGE   = 2'd1,
    MODE_RUN    = 2'd2
  } rd_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_PUB  = 2'd2
  } seq_state_e;

  localparam logic [21:0] READ_OP_LOW = 22'h000032;
  localparam int          PAGE_SEL_BIT = 23;
  localparam int          RUN_SEL_BIT  = 22;

endpackage

// File: rtl/cwseq_decode.sv
module cwseq_decode
  import cwseq_pkg::*;
(
  input  logic [31:0] cmd,
  output logic        legal,
  output rd_mode_e    mode,
  output logic        serial
);

  always_comb begin
    legal  = (cmd[21:0] == READ_OP_LOW);
    serial = |cmd[31:24];
    if (cmd[PAGE_SEL_BIT])     mode = MODE_PAGE;
    else if (cmd[RUN_SEL_BIT]) mode = MODE_RUN;
    else                       mode = MODE_SINGLE;
  end

endmodule

// File: rtl/cwseq_walker.sv
module cwseq_walker #(
  parameter int PAGE_W = 8,
  parameter int CW_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              single,
  input  logic [PAGE_W-1:0] page_lim,
  input  logic [CW_W-1:0]   cw_lim,
  input  logic [CW_W-1:0]   start_cw,
  input  logic              step,
  output logic [PAGE_W-1:0] page,
  output logic [CW_W-1:0]   cw,
  output logic              last
);

  logic [PAGE_W-1:0] page_q, page_lim_q;
  logic [CW_W-1:0]   cw_q, cw_lim_q;
  logic              single_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q     <= '0;
      cw_q       <= '0;
      page_lim_q <= '0;
      cw_lim_q   <= '0;
      single_q   <= 1'b0;
    end else if (load) begin
      page_q     <= '0;
      cw_q       <= start_cw;
      page_lim_q <= page_lim;
      cw_lim_q   <= cw_lim;
      single_q   <= single;
    end else if (step) begin
      if (cw_q == cw_lim_q) begin
        cw_q   <= '0;
        page_q <= page_q + PAGE_W'(1);
      end else begin
        cw_q <= cw_q + CW_W'(1);
      end
    end
  end

  assign page = page_q;
  assign cw   = cw_q;
  assign last = single_q || ((cw_q == cw_lim_q) && (page_q == page_lim_q));

endmodule

// File: rtl/cwseq_recsel.sv
module cwseq_recsel #(
  parameter int NREC   = 4,
  parameter int KIND_W = 2
) (
  input  logic [NREC-1:0]   mask,
  input  logic [KIND_W-1:0] ptr,
  output logic [KIND_W-1:0] first_idx,
  output logic              first_any,
  output logic [KIND_W-1:0] next_idx,
  output logic              next_any
);

  always_comb begin
    first_any = 1'b0;
    first_idx = '0;
    next_any  = 1'b0;
    next_idx  = '0;
    for (int i = NREC - 1; i >= 0; i--) begin
      if (mask[i]) begin
        first_any = 1'b1;
        first_idx = KIND_W'(i);
        if (i > int'(ptr)) begin
          next_any = 1'b1;
          next_idx = KIND_W'(i);
        end
      end
    end
  end

endmodule

// File: rtl/cw_page_seq.sv
module cw_page_seq
  import cwseq_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int CW_W   = 8,
  parameter int FLAG_W = 8,
  parameter int NREC   = 4
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic [31:0]                             cmd_word,
  input  logic [PAGE_W-1:0]                       mp_pages,
  input  logic [CW_W-1:0]                         cw_per_page,
  input  logic [NREC-1:0]                         stat_mask,
  input  logic                                    exec_go,
  output logic                                    rd_req,
  output logic [PAGE_W-1:0]                       rd_page,
  output logic [CW_W-1:0]                         rd_cw,
  output logic                                    rd_serial,
  input  logic                                    rd_ack,
  input  logic [FLAG_W-1:0]                       rd_flags,
  output logic                                    st_valid,
  input  logic                                    st_ready,
  output logic [$clog2(NREC)+PAGE_W+CW_W+FLAG_W:0] st_data,
  output logic                                    busy,
  output logic                                    done_irq,
  output logic                                    err_sticky,
  output logic [FLAG_W-1:0]                       stat_reg
);

  localparam int KIND_W = $clog2(NREC);

  seq_state_e        state_q, state_d;
  rd_mode_e          mode_q, dec_mode;
  logic              serial_q, dec_serial, dec_legal;
  logic [NREC-1:0]   mask_q;
  logic [KIND_W-1:0] kind_q, first_idx, next_idx;
  logic              first_any, next_any;
  logic [FLAG_W-1:0] flags_q;
  logic              done_q, err_q;
  logic [CW_W-1:0]   norm_idx_q, norm_rd, cw_lim, start_cw;
  logic [PAGE_W-1:0] page_lim;
  logic              accept, ack_hs, pub_hs, finish_cw, last_cw, step, complete;
  logic [PAGE_W-1:0] cur_page;
  logic [CW_W-1:0]   cur_cw;

  cwseq_decode u_dec (
    .cmd    (cmd_word),
    .legal  (dec_legal),
    .mode   (dec_mode),
    .serial (dec_serial)
  );

  assign busy   = (state_q != SQ_IDLE);
  assign accept = exec_go && !busy && dec_legal;

  // effective limits: zero counts as one
  assign cw_lim   = (cw_per_page == '0) ? '0 : cw_per_page - CW_W'(1);
  assign page_lim = (dec_mode != MODE_RUN || mp_pages == '0) ? '0
                                                             : mp_pages - PAGE_W'(1);
  assign norm_rd  = (norm_idx_q > cw_lim) ? '0 : norm_idx_q;
  assign start_cw = (dec_mode == MODE_SINGLE) ? norm_rd : '0;

  cwseq_walker #(.PAGE_W(PAGE_W), .CW_W(CW_W)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .single   (dec_mode == MODE_SINGLE),
    .page_lim (page_lim),
    .cw_lim   (cw_lim),
    .start_cw (start_cw),
    .step     (step),
    .page     (cur_page),
    .cw       (cur_cw),
    .last     (last_cw)
  );

  cwseq_recsel #(.NREC(NREC), .KIND_W(KIND_W)) u_sel (
    .mask      (mask_q),
    .ptr       (kind_q),
    .first_idx (first_idx),
    .first_any (first_any),
    .next_idx  (next_idx),
    .next_any  (next_any)
  );

  assign ack_hs    = (state_q == SQ_REQ) && rd_ack;
  assign pub_hs    = (state_q == SQ_PUB) && st_ready;
  assign finish_cw = (ack_hs && !first_any) || (pub_hs && !next_any);
  assign step      = finish_cw && !last_cw;
  assign complete  = finish_cw && last_cw;

  always_comb begin
    state_d = state_q;
    case (state_q)
      SQ_IDLE: if (accept) state_d = SQ_REQ;
      SQ_REQ: begin
        if (ack_hs) begin
          if (first_any)    state_d = SQ_PUB;
          else if (last_cw) state_d = SQ_IDLE;
          else              state_d = SQ_REQ;
        end
      end
      SQ_PUB: begin
        if (pub_hs) begin
          if (next_any)     state_d = SQ_PUB;
          else if (last_cw) state_d = SQ_IDLE;
          else              state_d = SQ_REQ;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= SQ_IDLE;
      mode_q     <= MODE_SINGLE;
      serial_q   <= 1'b0;
      mask_q     <= '0;
      kind_q     <= '0;
      flags_q    <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      norm_idx_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= complete;
      if (exec_go && (busy || !dec_legal)) err_q <= 1'b1;
      if (accept) begin
        mode_q   <= dec_mode;
        serial_q <= dec_serial;
        mask_q   <= stat_mask;
        if (dec_mode == MODE_SINGLE)
          norm_idx_q <= (norm_rd == cw_lim) ? '0 : norm_rd + CW_W'(1);
      end
      if (ack_hs) begin
        flags_q <= rd_flags;
        kind_q  <= first_idx;
      end else if (pub_hs && next_any) begin
        kind_q <= next_idx;
      end
    end
  end

  assign rd_req     = (state_q == SQ_REQ);
  assign rd_page    = cur_page;
  assign rd_cw      = cur_cw;
  assign rd_serial  = serial_q;
  assign st_valid   = (state_q == SQ_PUB);
  assign st_data    = {kind_q, serial_q, cur_page, cur_cw, flags_q};
  assign done_irq   = done_q;
  assign err_sticky = err_q;
  assign stat_reg   = (busy && mode_q != MODE_SINGLE) ? '0 : flags_q;

endmodule

// File: rtl/cwseq_checks.sv
module cwseq_checks #(
  parameter int SD_W = 27
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_req,
  input logic            rd_ack,
  input logic [7:0]      rd_page,
  input logic [7:0]      rd_cw,
  input logic            st_valid,
  input logic            st_ready,
  input logic [SD_W-1:0] st_data,
  input logic            busy,
  input logic            done_irq,
  input logic            err_sticky
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_page) && $stable(rd_cw)); // R6

  AST_REC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |=> st_valid && $stable(st_data)); // R8

  AST_NO_REQ_WHILE_REC: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && st_valid)); // R8

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq); // R9

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> !busy); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req && !st_valid); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky); // R10

endmodule

bind cw_page_seq cwseq_checks #(.SD_W($bits(st_data))) u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_req     (rd_req),
  .rd_ack     (rd_ack),
  .rd_page    (8'(rd_page)),
  .rd_cw      (8'(rd_cw)),
  .st_valid   (st_valid),
  .st_ready   (st_ready),
  .st_data    (st_data),
  .busy       (busy),
  .done_irq   (done_irq),
  .err_sticky (err_sticky)
);

// File: tb/tb_cw_page_seq.sv
module tb_cw_page_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cmd_word;
  logic [7:0]  mp_pages, cw_per_page, rd_flags;
  logic [3:0]  stat_mask;
  logic        exec_go, rd_ack, st_ready;
  logic        rd_req, rd_serial, st_valid, busy, done_irq, err_sticky;
  logic [7:0]  rd_page, rd_cw, stat_reg;
  logic [26:0] st_data;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int norm_exp = 0;

  always #5 clk = ~clk;

  cw_page_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .mp_pages(mp_pages),
    .cw_per_page(cw_per_page), .stat_mask(stat_mask), .exec_go(exec_go),
    .rd_req(rd_req), .rd_page(rd_page), .rd_cw(rd_cw), .rd_serial(rd_serial),
    .rd_ack(rd_ack), .rd_flags(rd_flags), .st_valid(st_valid), .st_ready(st_ready),
    .st_data(st_data), .busy(busy), .done_irq(done_irq), .err_sticky(err_sticky),
    .stat_reg(stat_reg)
  );

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [26:0] pack(input int kind, input bit ser, input int pg, input int cw, input logic [7:0] fl);
    return {2'(kind), ser, 8'(pg), 8'(cw), fl};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; exec_go = 0; rd_ack = 0; st_ready = 0;
    cmd_word = 0; mp_pages = 0; cw_per_page = 0; stat_mask = 0; rd_flags = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    norm_exp = 0;
    @(negedge clk);
    chk(!busy && !rd_req && !st_valid, "R1 idle outputs", {busy, rd_req, st_valid}, 0);
    chk(!done_irq && !err_sticky, "R1 done/err", {done_irq, err_sticky}, 0);
    chk(stat_reg == 0, "R1 stat_reg", stat_reg, 0);
  endtask

  // mode: 0 single, 1 page, 2 run
  task automatic run_op(input logic [31:0] cmd, input int pages, input int cwpp,
                        input logic [3:0] mask, input bit poke_busy);
    int mode, pe, ce, ncw, rd0;
    bit ser;
    logic [7:0] fl;
    string rq;
    mode = cmd[23] ? 1 : (cmd[22] ? 2 : 0);
    ser  = |cmd[31:24];
    ce   = (cwpp == 0) ? 1 : cwpp;
    pe   = (mode == 2) ? ((pages == 0) ? 1 : pages) : 1;
    rd0  = 0;
    if (mode == 0) begin
      rd0 = (norm_exp >= ce) ? 0 : norm_exp;
      norm_exp = (rd0 == ce - 1) ? 0 : rd0 + 1;
      ncw = 1;
    end else ncw = pe * ce;
    rq = (mode == 0) ? "R5" : ((mode == 1) ? "R3" : "R4");

    @(negedge clk);
    cmd_word = cmd; mp_pages = 8'(pages); cw_per_page = 8'(cwpp); stat_mask = mask;
    exec_go = 1'b1;
    @(negedge clk);
    exec_go = 1'b0;
    mp_pages = 8'($urandom); cw_per_page = 8'($urandom); stat_mask = 4'($urandom);
    cmd_word = $urandom;
    chk(busy, "R9 busy after execute", busy, 1);

    for (int k = 0; k < ncw; k++) begin
      int pg, cw, wt;
      bit last, fin_now;
      pg   = (mode == 0) ? 0 : k / ce;
      cw   = (mode == 0) ? rd0 : k % ce;
      last = (k == ncw - 1);
      wt = 0;
      while (!rd_req && wt < 20) begin @(negedge clk); wt++; end
      chk(rd_req, "R6 request raised", rd_req, 1);
      chk(rd_page == 8'(pg), {rq, " page index"}, rd_page, pg);
      chk(rd_cw == 8'(cw), {rq, " codeword index"}, rd_cw, cw);
      chk(rd_serial == ser, "R2 serial select", rd_serial, ser);
      if (mode != 0) chk(stat_reg == 0, "R11 hidden while busy", stat_reg, 0);
      if (poke_busy && k == 0) begin
        exec_go = 1'b1; cmd_word = 32'h00400032;
        @(negedge clk);
        exec_go = 1'b0;
        chk(err_sticky, "R10 execute while busy", err_sticky, 1);
      end
      for (int s = 0; s < int'($urandom % 3); s++) begin
        @(negedge clk);
        chk(rd_req && rd_page == 8'(pg) && rd_cw == 8'(cw), "R6 request held", rd_cw, cw);
      end
      fl = 8'($urandom);
      rd_flags = fl; rd_ack = 1'b1;
      @(negedge clk);
      rd_ack = 1'b0;
      fin_now = last && (mask == 0);
      chk(stat_reg == ((mode != 0 && !fin_now) ? 8'h00 : fl), "R11 stat_reg", stat_reg,
          (mode != 0 && !fin_now) ? 8'h00 : fl);
      for (int b = 0; b < 4; b++) begin
        if (mask[b]) begin
          logic [26:0] ex;
          ex = pack(b, ser, pg, cw, fl);
          chk(st_valid, "R7 record valid", st_valid, 1);
          chk(!rd_req, "R8 no request while record pending", rd_req, 0);
          chk(st_data == ex, "R7 record content", st_data, ex);
          for (int s = 0; s < int'($urandom % 3); s++) begin
            @(negedge clk);
            chk(st_valid && st_data == ex, "R8 record held", st_data, ex);
          end
          st_ready = 1'b1;
          @(negedge clk);
          st_ready = 1'b0;
        end
      end
      if (last) begin
        chk(done_irq && !busy, "R9 done pulse at end", {done_irq, busy}, 2'b10);
        chk(!st_valid && !rd_req, "R7 no extra record", {st_valid, rd_req}, 0);
        @(negedge clk);
        chk(!done_irq, "R9 done one cycle", done_irq, 0);
        chk(stat_reg == fl, "R11 stat_reg after run", stat_reg, fl);
      end else begin
        chk(!done_irq && busy, "R9 no early done", {done_irq, busy}, 2'b01);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // directed
    run_op(32'h78800032, 0, 4, 4'hF, 0);  // R3 serial page mode, all records
    run_op(32'h00400032, 3, 2, 4'b0101, 0);  // R4 parallel run
    run_op(32'h00800032, 0, 3, 4'h0, 0);  // R7 zero mask
    run_op(32'h78400032, 0, 2, 4'b1000, 0);  // R4 zero page count
    run_op(32'h00800032, 0, 0, 4'b0010, 0);  // R3 zero codeword count
    run_op(32'h78C00032, 2, 2, 4'b0001, 0);  // R2 page bit wins
    for (int i = 0; i < 4; i++) run_op(32'h78000032, 0, 3, 4'b0011, 0);  // R5 wrap
    run_op(32'h00000032, 0, 1, 4'h0, 0);  // R5 after shrink
    // random
    for (int i = 0; i < 25; i++) begin
      logic [31:0] c;
      case ($urandom % 5)
        0: c = 32'h78800032;
        1: c = 32'h78400032;
        2: c = 32'h00800032;
        3: c = 32'h00400032;
        default: c = 32'h78000032;
      endcase
      run_op(c, int'($urandom % 4), int'($urandom % 5), 4'($urandom), 0);
    end
    chk(!err_sticky, "R10 no error on clean runs", err_sticky, 0);
    // R10 execute while busy is ignored
    run_op(32'h78800032, 0, 3, 4'b0110, 1);
    chk(err_sticky, "R10 error sticks", err_sticky, 1);
    // R10 illegal command after reset
    do_reset();
    @(negedge clk);
    cmd_word = 32'h00800033; exec_go = 1'b1;
    @(negedge clk);
    exec_go = 1'b0;
    chk(!busy, "R10 illegal command ignored", busy, 0);
    chk(err_sticky, "R10 illegal command flags", err_sticky, 1);
    repeat (3) begin
      @(negedge clk);
      chk(!rd_req && !busy, "R10 stays idle", {rd_req, busy}, 0);
    end
    run_op(32'h00000032, 0, 2, 4'h1, 0);  // R5 index restarts at 0 after reset
    summary();
  end

endmodule